// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion. An external capacitor array and comparator do the analog work. The block drives them with a track/hold select and a trial code word, and reads back a single comparator bit. It then resolves the code one bit at a time, starting from the most significant bit. When every bit is known, it writes the whole code into a result register in one step.

Each conversion uses a frame of thirteen clock periods, numbered 1 to 13:

- Periods 1 to 3 track the input while the trial code is zero.
- Periods 4 to 13 hold the sample and test one bit per period.

Every state change happens on the rising clock edge. The period number is available as a status output so that surrounding logic can follow the phase.

An active-low start input selects the operating mode:

- **Free-running:** held low, the sequencer runs one conversion after another with no gap.
- **Triggered:** left high during period 1, the sequencer parks in period 2 and keeps tracking. A low level sampled at a rising edge releases it into period 3.

Start is only looked at in periods 1 and 2. It has no effect during a conversion.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is period 1, with `trial_code` = 0, `result` = 0 and `track_hold` = 0.
- R2: `period` always holds a value from 1 to 13. It advances by one per rising edge except when stalled. Period 13 is followed by period 1, so with `start_n` held low a conversion takes exactly 13 clocks.
- R3: `track_hold` is 0 (track) in periods 1 to 3 and 1 (hold) in periods 4 to 13. `trial_code` is 0 while tracking.
- R4: In period 4, `trial_code` is 0x200: only bit 9 is set.
- R5: At the end of each period p from 4 to 13, the bit being tested (bit 13−p) keeps the value of `cmp_in` sampled at that edge. For p below 13, the next lower bit is set to 1 in the trial of period p+1. Bits already decided are unchanged.
- R6: At the rising edge that ends period 13, `result` takes all ten bits at once, with bit 0 taken from `cmp_in` at that edge. `trial_code` returns to 0. `result` does not change at any other edge.
- R7: If `start_n` is high at the edge that ends period 1, the sequencer stays in period 2 with `track_hold` = 0 for as long as `start_n` stays high.
- R8: While stalled in period 2, a low `start_n` sampled at a rising edge moves the sequencer to period 3 at that edge.
- R9: The `start_n` level during periods 3 to 13 has no effect. A low pulse there neither changes the sequence nor prevents the stall after the next period 1.
- R10: With an ideal comparator (`cmp_in` = input ≥ `trial_code`), every input value from 0 to 1023 converts to exactly that value in `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start request; held low for free-running operation |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above the trial code |
| track_hold | output | 1 | 0 = track the input, 1 = hold the sample |
| trial_code | output | 10 | Trial code word for the capacitor array |
| result | output | 10 | Last completed conversion result |
| period | output | 4 | Current period of the frame, 1 to 13 |

## Verification
Every output is a register, so each result shows up one rising edge after the state that caused it:

- **Period and track/hold** change at the edge that leaves the current period.
- **Trial code** carries the new decision and the next trial bit from that same edge onward.
- **Result** changes only at the edge that ends period 13. That is 13 edges after the input was set in period 1 in free-running mode, or 11 edges after release from the period-2 stall.

A behavioural reference model in the bench steps on the same rising edge as the design. All outputs are compared at the falling edge, half a cycle after both have settled. Directed checks for the stall, the release and the ignored start pulses are sampled at falling edges counted from the stimulus. Stimulus is also changed only at falling edges, so the design and the model always sample identical inputs.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Default geometry of the conversion frame.
  localparam int unsigned DEF_DATA_W  = 10;
  localparam int unsigned DEF_TRACK_P = 3;
  // Period in which a triggered sequencer waits for a start request.
  localparam int unsigned WAIT_PERIOD = 2;

  // Period in which bit 'idx' is decided, for a frame of track_p tracking
  // periods followed by data_w bit trials (MSB first).
  function automatic int unsigned test_period(input int unsigned track_p,
                                              input int unsigned data_w,
                                              input int unsigned idx);
    return track_p + data_w - idx;
  endfunction

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned TRACK_P = DEF_TRACK_P,
  parameter int unsigned PER_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  output logic [PER_W-1:0] period_q,
  output logic             hold_q
);

  localparam int unsigned LAST = TRACK_P + DATA_W;
  localparam logic [PER_W-1:0] P_FIRST = PER_W'(1);
  localparam logic [PER_W-1:0] P_WAIT  = PER_W'(WAIT_PERIOD);
  localparam logic [PER_W-1:0] P_LAST  = PER_W'(LAST);
  localparam logic [PER_W-1:0] P_TRACK = PER_W'(TRACK_P);

  logic             armed_q;
  logic             armed_nxt;
  logic [PER_W-1:0] period_nxt;

  // Start is captured at the end of period 1 and consumed in the wait
  // period; in every other period it is not looked at.
  always_comb begin
    period_nxt = period_q + PER_W'(1);
    armed_nxt  = armed_q;
    if (period_q == P_FIRST) begin
      armed_nxt = ~start_n;
    end else if (period_q == P_WAIT) begin
      if (armed_q || !start_n) begin
        armed_nxt = 1'b0;
      end else begin
        period_nxt = period_q;
      end
    end else if (period_q == P_LAST) begin
      period_nxt = P_FIRST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= P_FIRST;
      armed_q  <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      period_q <= period_nxt;
      armed_q  <= armed_nxt;
      hold_q   <= (period_nxt > P_TRACK);
    end
  end

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
  import sar_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned TRACK_P = DEF_TRACK_P,
  parameter int unsigned PER_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  period,
  input  logic              cmp,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] result_o
);

  localparam logic [PER_W-1:0] P_LAST = PER_W'(TRACK_P + DATA_W);

  // One slice per bit position; the slice's test period follows from its
  // index, and it is proposed in the period just before that.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [PER_W-1:0] P_TEST = PER_W'(test_period(TRACK_P, DATA_W, i));
    localparam logic [PER_W-1:0] P_SET  = P_TEST - PER_W'(1);

    logic trial_q;
    logic res_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        trial_q <= 1'b0;
        res_q   <= 1'b0;
      end else if (period == P_LAST) begin
        trial_q <= 1'b0;
        res_q   <= (i == 0) ? cmp : trial_q;
      end else if (period == P_TEST) begin
        trial_q <= cmp;
      end else if (period == P_SET) begin
        trial_q <= 1'b1;
      end
    end

    assign trial_o[i]  = trial_q;
    assign result_o[i] = res_q;
  end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned TRACK_P = DEF_TRACK_P,
  localparam int unsigned PER_W  = $clog2(TRACK_P + DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic              cmp_in,
  output logic              track_hold,
  output logic [DATA_W-1:0] trial_code,
  output logic [DATA_W-1:0] result,
  output logic [PER_W-1:0]  period
);

  sar_phase_ctrl #(
    .DATA_W (DATA_W),
    .TRACK_P(TRACK_P),
    .PER_W  (PER_W)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .period_q(period),
    .hold_q  (track_hold)
  );

  sar_bit_reg #(
    .DATA_W (DATA_W),
    .TRACK_P(TRACK_P),
    .PER_W  (PER_W)
  ) u_bits (
    .clk     (clk),
    .rst     (rst),
    .period  (period),
    .cmp     (cmp_in),
    .trial_o (trial_code),
    .result_o(result)
  );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned TRACK_P = 3,
  parameter int unsigned PER_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_n,
  input logic              track_hold,
  input logic [DATA_W-1:0] trial_code,
  input logic [DATA_W-1:0] result,
  input logic [PER_W-1:0]  period
);

  localparam logic [PER_W-1:0]  P_LAST  = PER_W'(TRACK_P + DATA_W);
  localparam logic [PER_W-1:0]  P_TRACK = PER_W'(TRACK_P);
  localparam logic [PER_W-1:0]  P_WAIT  = PER_W'(2);
  localparam logic [DATA_W-1:0] MSB_ONLY = DATA_W'(1) << (DATA_W - 1);

  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (period >= PER_W'(1)) && (period <= P_LAST)); // R2

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (period == P_LAST) |=> (period == PER_W'(1))); // R2

  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (rst)
    track_hold == (period > P_TRACK)); // R3

  AST_TRACK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (period <= P_TRACK) |-> (trial_code == '0)); // R3

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    (period == P_TRACK) |=> (trial_code == MSB_ONLY)); // R4

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (period != P_LAST) |=> $stable(result)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (period == P_WAIT && $past(period) == P_WAIT && start_n) |=> (period == P_WAIT)); // R7

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
  .DATA_W (DATA_W),
  .TRACK_P(TRACK_P),
  .PER_W  (PER_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_n   (start_n),
  .track_hold(track_hold),
  .trial_code(trial_code),
  .result    (result),
  .period    (period)
);

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_n = 1'b0;
  logic       cmp_in;
  logic       track_hold;
  logic [9:0] trial_code;
  logic [9:0] result;
  logic [3:0] period;
  int         analog = 0;

  int  total = 0;
  int  bad = 0;
  bit  cmp_on = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  // Ideal comparator closing the loop.
  assign cmp_in = (analog >= int'(trial_code));

  sar_conv_seq u_dut (
    .clk       (clk),
    .rst       (rst),
    .start_n   (start_n),
    .cmp_in    (cmp_in),
    .track_hold(track_hold),
    .trial_code(trial_code),
    .result    (result),
    .period    (period)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on the same edge as the design.
  int        m_p = 1;
  bit        m_arm = 1'b0;
  bit        m_hold = 1'b0;
  bit  [9:0] m_trial = '0;
  bit  [9:0] m_res = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_p = 1; m_arm = 0; m_trial = '0; m_res = '0; m_hold = 0;
    end else begin
      bit c;
      c = (analog >= int'(m_trial));
      if (m_p == 1) begin
        m_arm = !start_n; m_p = 2;
      end else if (m_p == 2) begin
        if (m_arm || !start_n) begin m_arm = 0; m_p = 3; end
      end else if (m_p == 3) begin
        m_trial = 10'h200; m_p = 4;
      end else begin
        m_trial[13 - m_p] = c;
        if (m_p == 13) begin
          m_res = m_trial; m_trial = '0; m_p = 1;
        end else begin
          m_trial[12 - m_p] = 1'b1; m_p = m_p + 1;
        end
      end
      m_hold = (m_p >= 4);
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk(int'(period) == m_p, "R2 period", int'(period), m_p);
      chk(track_hold == m_hold, "R3 track_hold", int'(track_hold), int'(m_hold));
      chk(trial_code == m_trial, "R5 trial_code", int'(trial_code), int'(m_trial));
      chk(result == m_res, "R6 result", int'(result), int'(m_res));
      if (m_p == 4) chk(trial_code == 10'h200, "R4 msb trial", int'(trial_code), 512);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WATCHDOG", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(period == 4'd1, "R1 period", int'(period), 1);
    chk(trial_code == '0, "R1 trial_code", int'(trial_code), 0);
    chk(result == '0, "R1 result", int'(result), 0);
    chk(track_hold == 1'b0, "R1 track_hold", int'(track_hold), 0);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R10 / R2: free-running sweep of every code, 13 clocks each
    for (int code = 0; code < 1024; code++) begin
      analog = code;
      repeat (13) @(negedge clk);
      chk(period == 4'd1, "R2 frame length", int'(period), 1);
      chk(int'(result) == code, "R10 exact code", int'(result), code);
    end

    // R7: start high through period 1 parks the sequencer in period 2
    start_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(period == 4'd2, "R7 stalled period", int'(period), 2);
    chk(track_hold == 1'b0, "R7 still tracking", int'(track_hold), 0);

    // R8: a low start sampled at one edge releases into period 3
    analog = 700;
    start_n = 1'b0;
    @(negedge clk);
    chk(period == 4'd3, "R8 release", int'(period), 3);
    start_n = 1'b1;

    // R9: start pulse mid-conversion is ignored
    while (period != 4'd6) @(negedge clk);
    start_n = 1'b0;
    repeat (2) @(negedge clk);
    start_n = 1'b1;
    while (period != 4'd1) @(negedge clk);
    chk(int'(result) == 700, "R6 triggered result", int'(result), 700);
    repeat (20) @(negedge clk);
    chk(period == 4'd2, "R9 stall after ignored pulse", int'(period), 2);
    chk(int'(result) == 700, "R9 result kept", int'(result), 700);

    // R8 / R10: second triggered conversion, 11 edges from period 3
    analog = 1023;
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    chk(period == 4'd3, "R8 second release", int'(period), 3);
    repeat (11) @(negedge clk);
    chk(period == 4'd1, "R2 back to period 1", int'(period), 1);
    chk(int'(result) == 1023, "R10 full scale", int'(result), 1023);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule